// File: doc/BRIEF.md
# Sign-Magnitude Adder/Subtracter

This combinational unit accepts two signed operands written in sign-magnitude notation, together with a one-bit operation select. It either sums the operands or takes the second away from the first, and it presents the answer as a two's complement value. The result is one bit wider than an operand, so every possible answer fits and no overflow can occur.

Internally, each operand is turned into two's complement by XOR-gating its magnitude with its sign and then adding the sign back in as a carry. When the unit subtracts, the sign of the second operand is flipped before that conversion, so subtraction needs no separate path. Both additions are done by a carry-lookahead stage. In that stage every carry is a flat sum of products of per-bit generate and propagate terms. A small control piece derives the two negate strobes from the signs and the select. A datapath piece holds the XOR gating and the two lookahead adders.

Top module: `smAddSub`

## Requirements
- R1: Operand format: bit 3 of each operand is the sign (1 means negative) and bits 2:0 are the magnitude, giving values -7 to +7. With mode = 0 the result equals A + B.
- R2: With mode = 1 the result equals A - B.
- R3: The result is a 5-bit two's complement word, and its value always lies between -14 and +14.
- R4: A negative-zero operand (sign 1, magnitude 0) gives the same result as positive zero.
- R5: Applying mode = 1 to an operand B gives the same result as applying mode = 0 to B with its sign bit inverted.
- R6: Subtracting an operand from an operand of equal value gives zero.
- R7: At the extremes, -7 + -7 gives -14 (5'b10010) and +7 - (-7) gives +14 (5'b01110).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 4 | First operand, sign in bit 3, magnitude in bits 2:0 |
| opB | input | 4 | Second operand, same format |
| mode | input | 1 | 0 selects A + B, 1 selects A - B |
| result | output | 5 | Two's complement sum or difference |

## Verification
Every operand pair is applied in both modes and compared with an integer reference. This exercises all four combinations of operand signs, so any error in the per-operand conversion or in the sign flip for subtraction is caught. Directed cases come next. Negative-zero operands separate a correct conversion from one that yields -16 or -1. The extreme sums drive carries through all lookahead positions, which exposes a missing or wrong product term. Equal-operand subtraction and pairs that differ only in the sign of B cover the zero result and the sign-flip equivalence.

// File: rtl/smAddSubPkg.sv
package smAddSubPkg;
  typedef struct packed {
    logic negA;
    logic negB;
  } smCtrl_t;
endpackage

// File: rtl/smCla.sv
module smCla #(
  parameter int W = 5
) (
  input  logic [W-1:0] aIn,
  input  logic [W-1:0] bIn,
  input  logic         cIn,
  output logic [W-1:0] sum,
  output logic         cOut
);
  logic [W-1:0] gen;
  logic [W-1:0] prop;
  logic [W:0]   carry;

  assign gen  = aIn & bIn;
  assign prop = aIn ^ bIn;

  // each carry is a two-level sum of products, no chained terms
  always_comb begin
    carry[0] = cIn;
    for (int i = 0; i < W; i++) begin
      logic acc;
      acc = cIn;
      for (int j = 0; j <= i; j++) acc = acc & prop[j];
      for (int k = 0; k <= i; k++) begin
        logic term;
        term = gen[k];
        for (int j = k + 1; j <= i; j++) term = term & prop[j];
        acc = acc | term;
      end
      carry[i+1] = acc;
    end
  end

  assign sum  = prop ^ carry[W-1:0];
  assign cOut = carry[W];
endmodule

// File: rtl/smCtrl.sv
module smCtrl
  import smAddSubPkg::*;
(
  input  logic    signA,
  input  logic    signB,
  input  logic    subSel,
  output smCtrl_t strobes
);
  assign strobes.negA = signA;
  assign strobes.negB = signB ^ subSel;
endmodule

// File: rtl/smDatapath.sv
module smDatapath
  import smAddSubPkg::*;
#(
  parameter int MAG_W = 3,
  localparam int RES_W = MAG_W + 2
) (
  input  logic [MAG_W-1:0] magA,
  input  logic [MAG_W-1:0] magB,
  input  smCtrl_t          strobes,
  output logic [RES_W-1:0] res
);
  localparam int PAD_W = RES_W - MAG_W;

  logic [RES_W-1:0] extA, extB, gatedA, gatedB, convA;
  logic             unusedA, unusedS;

  assign extA   = {{PAD_W{1'b0}}, magA};
  assign extB   = {{PAD_W{1'b0}}, magB};
  assign gatedA = extA ^ {RES_W{strobes.negA}};
  assign gatedB = extB ^ {RES_W{strobes.negB}};

  // operand A: inversion plus one through its own lookahead stage
  smCla #(.W(RES_W)) convA_i (
    .aIn(gatedA), .bIn('0), .cIn(strobes.negA), .sum(convA), .cOut(unusedA)
  );

  // operand B's "+1" rides in as the carry of the main sum
  smCla #(.W(RES_W)) sum_i (
    .aIn(convA), .bIn(gatedB), .cIn(strobes.negB), .sum(res), .cOut(unusedS)
  );
endmodule

// File: rtl/smAddSub.sv
module smAddSub
  import smAddSubPkg::*;
#(
  parameter int MAG_W = 3,
  localparam int OP_W  = MAG_W + 1,
  localparam int RES_W = MAG_W + 2
) (
  input  logic [OP_W-1:0]  opA,
  input  logic [OP_W-1:0]  opB,
  input  logic             mode,
  output logic [RES_W-1:0] result
);
  smCtrl_t strobes;

  smCtrl ctrl_i (
    .signA(opA[OP_W-1]), .signB(opB[OP_W-1]), .subSel(mode), .strobes(strobes)
  );

  smDatapath #(.MAG_W(MAG_W)) dp_i (
    .magA(opA[MAG_W-1:0]), .magB(opB[MAG_W-1:0]), .strobes(strobes), .res(result)
  );
endmodule

// File: rtl/smAddSubChk.sv
module smAddSubChk #(
  parameter int MAG_W = 3,
  localparam int OP_W  = MAG_W + 1,
  localparam int RES_W = MAG_W + 2
) (
  input logic [OP_W-1:0]  opA,
  input logic [OP_W-1:0]  opB,
  input logic             mode,
  input logic [RES_W-1:0] result
);
  localparam int LIM = 2 * ((1 << MAG_W) - 1);

  int valA, valB, got;

  always_comb begin
    valA = opA[OP_W-1] ? -int'(opA[MAG_W-1:0]) : int'(opA[MAG_W-1:0]);
    valB = opB[OP_W-1] ? -int'(opB[MAG_W-1:0]) : int'(opB[MAG_W-1:0]);
    got  = int'($signed(result));
    if (!$isunknown({opA, opB, mode, result})) begin
      a_r3_in_range: assert (got >= -LIM && got <= LIM);
      if (!mode) begin
        a_r1_sum: assert (got == valA + valB);
      end else begin
        a_r2_diff: assert (got == valA - valB);
      end
      if (mode && valA == valB) begin
        a_r6_zero: assert (result == '0);
      end
      if (opA[MAG_W-1:0] == '0) begin
        a_r4_negzero: assert (got == (mode ? -valB : valB));
      end
    end
  end
endmodule

bind smAddSub smAddSubChk #(.MAG_W(MAG_W)) chk_i (
  .opA(opA), .opB(opB), .mode(mode), .result(result)
);

// File: tb/smAddSub_tb.sv
module smAddSub_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  typedef struct {
    logic [4:0] expect5;
    string      tag;
    logic [3:0] a;
    logic [3:0] b;
    logic       m;
  } item_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] opA = '0;
  logic [3:0] opB = '0;
  logic       mode = 1'b0;
  logic [4:0] result;

  int   checks = 0;
  int   fails  = 0;
  int   cycles = 0;
  bit   done   = 1'b0;
  item_t sbQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  smAddSub dut_i (.opA(opA), .opB(opB), .mode(mode), .result(result));

  function automatic int smVal(logic [3:0] v);
    return v[3] ? -int'(v[2:0]) : int'(v[2:0]);
  endfunction

  task automatic drive(logic [3:0] a, logic [3:0] b, logic m, string tag);
    item_t it;
    int    r;
    @(negedge clk);
    opA = a; opB = b; mode = m;
    r = m ? smVal(a) - smVal(b) : smVal(a) + smVal(b);
    it.expect5 = 5'(r);
    it.tag = tag; it.a = a; it.b = b; it.m = m;
    sbQ.push_back(it);
  endtask

  task automatic driveExp(logic [3:0] a, logic [3:0] b, logic m, logic [4:0] e, string tag);
    item_t it;
    @(negedge clk);
    opA = a; opB = b; mode = m;
    it.expect5 = e; it.tag = tag; it.a = a; it.b = b; it.m = m;
    sbQ.push_back(it);
  endtask

  // monitor: compares at the edge following each drive
  always @(posedge clk) begin
    if (rstN && sbQ.size() > 0) begin
      item_t it;
      it = sbQ.pop_front();
      checks++;
      if (result !== it.expect5) begin
        fails++;
        $display("FAIL %s a=%b b=%b m=%0d actual=%b expected=%b",
                 it.tag, it.a, it.b, it.m, result, it.expect5);
      end
      if ($signed(result) > 14 || $signed(result) < -14) begin
        fails++;
        $display("FAIL R3 range actual=%0d expected=-14..14", $signed(result));
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // reset state: zero inputs give zero (R1)
    driveExp(4'b0000, 4'b0000, 1'b0, 5'b00000, "R1 reset");
    // exhaustive sweep, both modes (R1, R2, R3)
    for (int m = 0; m < 2; m++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          drive(4'(a), 4'(b), 1'(m), m ? "R2 sweep" : "R1 sweep");
    // negative zero behaves as zero (R4)
    driveExp(4'b1000, 4'b0011, 1'b0, 5'b00011, "R4 negzero A add");
    driveExp(4'b0101, 4'b1000, 1'b1, 5'b00101, "R4 negzero B sub");
    driveExp(4'b1000, 4'b1000, 1'b0, 5'b00000, "R4 negzero both");
    // sign flip equivalence (R5)
    driveExp(4'b0010, 4'b0110, 1'b1, 5'b11100, "R5 sub pos");
    driveExp(4'b0010, 4'b1110, 1'b0, 5'b11100, "R5 add neg");
    driveExp(4'b1011, 4'b1001, 1'b1, 5'b11110, "R5 sub neg");
    driveExp(4'b1011, 4'b0001, 1'b0, 5'b11110, "R5 add pos");
    // equal operands subtract to zero (R6)
    driveExp(4'b0111, 4'b0111, 1'b1, 5'b00000, "R6 pos");
    driveExp(4'b1101, 4'b1101, 1'b1, 5'b00000, "R6 neg");
    // extremes (R7)
    driveExp(4'b1111, 4'b1111, 1'b0, 5'b10010, "R7 min");
    driveExp(4'b0111, 4'b1111, 1'b1, 5'b01110, "R7 max");
    driveExp(4'b1111, 4'b0111, 1'b1, 5'b10010, "R7 min sub");
    @(negedge clk);
    @(negedge clk);
    if (sbQ.size() != 0) begin
      fails++;
      $display("FAIL scoreboard actual=%0d pending expected=0", sbQ.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule